// File: doc/BRIEF.md
# Supervisor Virtualization Trap Gate

This block sits next to a small privileged control-register unit and decides, for every decoded system operation, whether that operation is allowed or must raise an illegal-instruction exception. It holds three machine-level trap-control bits and the address-translation root register. The trap-control bits are: trap virtual-memory management, trap supervisor return, and timeout-wait. When the hart runs in supervisor mode, these bits let a hypervisor or monitor running in machine mode intercept page-table root accesses, TLB fences, wait-for-interrupt, and supervisor returns.

Each operation arrives as a single-cycle strobe with a type code, the current privilege mode, a select for the newer privileged-spec rules, and write data. One cycle later the block answers with at most one pulse: illegal-instruction, TLB flush, or halt request. It also returns read data for translation-root reads. The gating applies only when the newer-spec select is high. A translation-root write that traps leaves the register unchanged and does not flush the TLB.

Top module: `svt_trap_unit`

## Requirements
- R1: After reset the three trap-control bits are clear, the translation root is zero, and no pulse is asserted.
- R2: A machine status write (op code 5) copies write-data bit 20 into the VM-trap bit, bit 21 into the wait-trap bit and bit 22 into the return-trap bit. All other data bits are ignored, and the write produces no pulse.
- R3: A supervisor return (op code 0) raises illegal-instruction when the newer-spec select is high and the return-trap bit is set, whatever the privilege mode. Otherwise it produces no pulse.
- R4: A wait-for-interrupt (op code 1) raises illegal-instruction in supervisor mode when the newer-spec select is high and the wait-trap bit is set. Otherwise it asserts the halt request.
- R5: A TLB fence (op code 2) raises illegal-instruction in supervisor mode when the newer-spec select is high and the VM-trap bit is set. Otherwise it pulses the flush output.
- R6: A translation-root read (op code 3) raises illegal-instruction and returns zero in supervisor mode when the newer-spec select is high and the VM-trap bit is set. Otherwise it returns the register value. Read data is zero after every strobe that is not a granted read.
- R7: A translation-root write (op code 4) is accepted only when its mode field (bits 63:60) is 0, 8 or 9 and the written value differs from the current one in mode, ASID (bits 59:44) or PPN (bits 43:0). An accepted write updates the register and pulses flush. Any other write changes nothing and produces no pulse.
- R8: A translation-root write that would be accepted raises illegal-instruction in supervisor mode when the newer-spec select is high and the VM-trap bit is set. In that case the register keeps its old value and no flush is issued.
- R9: When built without an MMU, translation-root reads return zero without trapping, and translation-root writes have no effect and produce no pulse.
- R10: The pulses are registered, appear exactly in the cycle after the strobe, last one cycle, and at most one is high. Op codes 6 and 7, and cycles without a strobe, produce no pulse.
- R11: Privilege is encoded 00 user, 01 supervisor, 11 machine. The VM-trap and wait-trap bits never cause a trap in user or machine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_mode | input | 2 | Current privilege mode |
| spec_new | input | 1 | Selects newer privileged-spec gating |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 3 | Operation type code |
| op_wdata | input | XLEN | Write data for status and translation-root writes |
| illegal_pulse | output | 1 | Illegal-instruction exception pulse |
| flush_pulse | output | 1 | TLB flush request pulse |
| halt_pulse | output | 1 | Halt request pulse |
| satp_rdata | output | XLEN | Translation-root read data |

## Verification
The bench targets a translation-root write in trapped supervisor mode: a faulty design would overwrite the register or flush while trapping. It also writes an unchanged value under the VM trap, where a design that checks the trap before acceptance would raise a spurious exception. Supervisor return is issued from user and machine mode to catch a design that wrongly qualifies it by privilege. Every gated operation is repeated with the older-spec select, where a design that ignores the select would trap. A second instance built without an MMU is checked for zero read data and silent writes. An unsupported translation mode is written to catch a design that accepts any mode.

// File: rtl/svt_pkg.sv
package svt_pkg;
   typedef enum logic [2:0] {
      OP_SRET     = 3'd0,
      OP_WFI      = 3'd1,
      OP_SFENCE   = 3'd2,
      OP_ROOT_RD  = 3'd3,
      OP_ROOT_WR  = 3'd4,
      OP_STAT_WR  = 3'd5
   } svt_op_e;

   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_S = 2'b01;
   localparam logic [1:0] PRIV_M = 2'b11;

   localparam int VMTRAP_POS  = 20;
   localparam int WAITRAP_POS = 21;
   localparam int RETTRAP_POS = 22;
endpackage

// File: rtl/svt_trap_bits.sv
module svt_trap_bits (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wbits,
   output logic       vm_trap,
   output logic       wait_trap,
   output logic       ret_trap
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vm_trap   <= 1'b0;
         wait_trap <= 1'b0;
         ret_trap  <= 1'b0;
      end else if (wr_en) begin
         vm_trap   <= wbits[0];
         wait_trap <= wbits[1];
         ret_trap  <= wbits[2];
      end
   end
endmodule

// File: rtl/svt_root_reg.sv
module svt_root_reg #(
   parameter int XLEN       = 64,
   parameter bit HAS_MMU    = 1'b1,
   parameter bit ALLOW_SV48 = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            commit,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] root_q,
   output logic            acceptable
);
   localparam int MODE_W = (XLEN == 64) ? 4 : 1;
   localparam int ASID_W = (XLEN == 64) ? 16 : 9;
   localparam int PPN_W  = XLEN - MODE_W - ASID_W;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("svt_root_reg: XLEN must be 32 or 64");
   end

   if (HAS_MMU) begin : g_mmu
      logic [MODE_W-1:0] new_mode, cur_mode;
      logic [ASID_W-1:0] new_asid, cur_asid;
      logic [PPN_W-1:0]  new_ppn,  cur_ppn;
      logic              mode_ok;
      logic              differs;

      assign new_mode = wdata[XLEN-1 -: MODE_W];
      assign cur_mode = root_q[XLEN-1 -: MODE_W];
      assign new_asid = wdata[XLEN-1-MODE_W -: ASID_W];
      assign cur_asid = root_q[XLEN-1-MODE_W -: ASID_W];
      assign new_ppn  = wdata[PPN_W-1:0];
      assign cur_ppn  = root_q[PPN_W-1:0];

      if (XLEN == 64) begin : g_mode64
         always_comb begin
            mode_ok = (new_mode == 4'd0) || (new_mode == 4'd8) ||
                      (ALLOW_SV48 && (new_mode == 4'd9));
         end
      end else begin : g_mode32
         assign mode_ok = 1'b1;
      end

      assign differs    = (new_mode != cur_mode) || (new_asid != cur_asid) ||
                          (new_ppn != cur_ppn);
      assign acceptable = mode_ok && differs;

      always_ff @(posedge clk) begin
         if (!rst_n)      root_q <= '0;
         else if (commit) root_q <= wdata;
      end
   end else begin : g_nommu
      assign root_q     = '0;
      assign acceptable = 1'b0;
   end
endmodule

// File: rtl/svt_gate.sv
module svt_gate
   import svt_pkg::*;
#(
   parameter bit HAS_MMU = 1'b1
) (
   input  logic       op_valid,
   input  logic [2:0] op_kind,
   input  logic [1:0] priv_mode,
   input  logic       spec_new,
   input  logic       vm_trap,
   input  logic       wait_trap,
   input  logic       ret_trap,
   input  logic       root_acceptable,
   output logic       ill,
   output logic       flush,
   output logic       halt,
   output logic       rd_grant,
   output logic       root_commit,
   output logic       stat_wr
);
   logic in_super;
   logic vm_block;

   assign in_super = (priv_mode == PRIV_S);
   assign vm_block = spec_new && in_super && vm_trap;

   always_comb begin
      ill         = 1'b0;
      flush       = 1'b0;
      halt        = 1'b0;
      rd_grant    = 1'b0;
      root_commit = 1'b0;
      stat_wr     = 1'b0;
      if (op_valid) begin
         case (op_kind)
            OP_SRET: ill = spec_new && ret_trap;
            OP_WFI: begin
               ill  = spec_new && in_super && wait_trap;
               halt = !(spec_new && in_super && wait_trap);
            end
            OP_SFENCE: begin
               ill   = vm_block;
               flush = !vm_block;
            end
            OP_ROOT_RD: begin
               ill      = HAS_MMU && vm_block;
               rd_grant = HAS_MMU && !vm_block;
            end
            OP_ROOT_WR: begin
               if (root_acceptable) begin
                  ill         = vm_block;
                  flush       = !vm_block;
                  root_commit = !vm_block;
               end
            end
            OP_STAT_WR: stat_wr = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/svt_trap_unit.sv
module svt_trap_unit
   import svt_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter bit HAS_MMU    = 1'b1,
   parameter bit ALLOW_SV48 = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      priv_mode,
   input  logic            spec_new,
   input  logic            op_valid,
   input  logic [2:0]      op_kind,
   input  logic [XLEN-1:0] op_wdata,
   output logic            illegal_pulse,
   output logic            flush_pulse,
   output logic            halt_pulse,
   output logic [XLEN-1:0] satp_rdata
);
   logic            vm_trap, wait_trap, ret_trap;
   logic [XLEN-1:0] root_q;
   logic            root_acceptable;
   logic            ill_d, flush_d, halt_d, rd_grant, root_commit, stat_wr;

   svt_trap_bits u_bits (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (stat_wr),
      .wbits    ({op_wdata[RETTRAP_POS], op_wdata[WAITRAP_POS], op_wdata[VMTRAP_POS]}),
      .vm_trap  (vm_trap),
      .wait_trap(wait_trap),
      .ret_trap (ret_trap)
   );

   svt_root_reg #(
      .XLEN      (XLEN),
      .HAS_MMU   (HAS_MMU),
      .ALLOW_SV48(ALLOW_SV48)
   ) u_root (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (root_commit),
      .wdata     (op_wdata),
      .root_q    (root_q),
      .acceptable(root_acceptable)
   );

   svt_gate #(.HAS_MMU(HAS_MMU)) u_gate (
      .op_valid       (op_valid),
      .op_kind        (op_kind),
      .priv_mode      (priv_mode),
      .spec_new       (spec_new),
      .vm_trap        (vm_trap),
      .wait_trap      (wait_trap),
      .ret_trap       (ret_trap),
      .root_acceptable(root_acceptable),
      .ill            (ill_d),
      .flush          (flush_d),
      .halt           (halt_d),
      .rd_grant       (rd_grant),
      .root_commit    (root_commit),
      .stat_wr        (stat_wr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         illegal_pulse <= 1'b0;
         flush_pulse   <= 1'b0;
         halt_pulse    <= 1'b0;
         satp_rdata    <= '0;
      end else begin
         illegal_pulse <= ill_d;
         flush_pulse   <= flush_d;
         halt_pulse    <= halt_d;
         if (op_valid) satp_rdata <= rd_grant ? root_q : '0;
      end
   end
endmodule

// File: rtl/svt_trap_unit_chk.sv
module svt_trap_unit_chk
   import svt_pkg::*;
#(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      priv_mode,
   input logic            spec_new,
   input logic            op_valid,
   input logic [2:0]      op_kind,
   input logic            illegal_pulse,
   input logic            flush_pulse,
   input logic            halt_pulse,
   input logic            ret_trap,
   input logic [XLEN-1:0] root_q
);
   p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({illegal_pulse, flush_pulse, halt_pulse}));

   p_pulse_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal_pulse || flush_pulse || halt_pulse) |-> $past(op_valid));

   p_ret_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == OP_SRET) |=>
         (illegal_pulse == ($past(spec_new) && $past(ret_trap))));

   p_machine_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == OP_WFI && priv_mode == PRIV_M) |=> halt_pulse);

   p_root_change_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (root_q != $past(root_q)) |-> flush_pulse);

   p_trap_keeps_root_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_pulse |-> (root_q == $past(root_q)));

   p_status_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == OP_STAT_WR) |=>
         !(illegal_pulse || flush_pulse || halt_pulse));
endmodule

bind svt_trap_unit svt_trap_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .priv_mode    (priv_mode),
   .spec_new     (spec_new),
   .op_valid     (op_valid),
   .op_kind      (op_kind),
   .illegal_pulse(illegal_pulse),
   .flush_pulse  (flush_pulse),
   .halt_pulse   (halt_pulse),
   .ret_trap     (ret_trap),
   .root_q       (root_q)
);

// File: tb/svt_trap_unit_bench.sv
`timescale 1ns/1ps
module svt_trap_unit_bench;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      priv_mode = 2'b11;
   logic            spec_new = 1'b1;
   logic            op_valid = 1'b0;
   logic [2:0]      op_kind = 3'd7;
   logic [XLEN-1:0] op_wdata = '0;
   logic            ill, fl, hl;
   logic [XLEN-1:0] rd;
   logic            n_ill, n_fl, n_hl;
   logic [XLEN-1:0] n_rd;

   always #10 clk = ~clk;

   svt_trap_unit #(.XLEN(XLEN)) u_svt_trap_unit (
      .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .spec_new(spec_new),
      .op_valid(op_valid), .op_kind(op_kind), .op_wdata(op_wdata),
      .illegal_pulse(ill), .flush_pulse(fl), .halt_pulse(hl), .satp_rdata(rd));

   svt_trap_unit #(.XLEN(XLEN), .HAS_MMU(1'b0)) u_svt_trap_unit_nommu (
      .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .spec_new(spec_new),
      .op_valid(op_valid), .op_kind(op_kind), .op_wdata(op_wdata),
      .illegal_pulse(n_ill), .flush_pulse(n_fl), .halt_pulse(n_hl), .satp_rdata(n_rd));

   typedef struct {
      logic            ill, fl, hl;
      logic [XLEN-1:0] rd;
      string           tag;
   } exp_t;

   exp_t q[$];
   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   logic            m_vm = 0, m_wait = 0, m_ret = 0;
   logic [XLEN-1:0] m_root = '0;

   task automatic issue(input logic [2:0] k, input logic [1:0] p, input logic sn,
                        input logic [XLEN-1:0] wd, input string tag);
      exp_t e;
      logic vmb;
      logic [3:0] md;
      e.ill = 0; e.fl = 0; e.hl = 0; e.rd = '0; e.tag = tag;
      vmb = sn && (p == 2'b01) && m_vm;
      case (k)
         3'd0: e.ill = sn && m_ret;
         3'd1: begin
            e.ill = sn && (p == 2'b01) && m_wait;
            e.hl  = !e.ill;
         end
         3'd2: begin e.ill = vmb; e.fl = !vmb; end
         3'd3: begin e.ill = vmb; e.rd = vmb ? '0 : m_root; end
         3'd4: begin
            md = wd[63:60];
            if ((md == 4'd0 || md == 4'd8 || md == 4'd9) && wd != m_root) begin
               e.ill = vmb;
               e.fl  = !vmb;
               if (!vmb) m_root = wd;
            end
         end
         3'd5: begin m_vm = wd[20]; m_wait = wd[21]; m_ret = wd[22]; end
         default: ;
      endcase
      @(negedge clk);
      priv_mode = p; spec_new = sn; op_kind = k; op_wdata = wd; op_valid = 1'b1;
      q.push_back(e);
      @(negedge clk);
      op_valid = 1'b0; op_kind = 3'd7; op_wdata = 64'hDEAD_BEEF_0BAD_F00D;
   endtask

   always @(posedge clk) begin : mon
      logic       strobe;
      logic [2:0] kd;
      exp_t       e;
      strobe = op_valid && rst_n;
      kd = op_kind;
      #5;
      if (strobe && !finished) begin
         if (q.size() == 0) begin
            compared++; mismatched++;
            $display("FAIL R10 pulse without expected item: ill=%0b fl=%0b hl=%0b expected none", ill, fl, hl);
         end else begin
            e = q.pop_front();
            compared++;
            if (ill !== e.ill || fl !== e.fl || hl !== e.hl || rd !== e.rd) begin
               mismatched++;
               $display("FAIL %s: ill=%0b fl=%0b hl=%0b rd=%h expected ill=%0b fl=%0b hl=%0b rd=%h",
                        e.tag, ill, fl, hl, rd, e.ill, e.fl, e.hl, e.rd);
            end
         end
         if (kd == 3'd3 || kd == 3'd4) begin
            compared++;
            if (n_rd !== '0 || n_ill !== 1'b0 || n_fl !== 1'b0) begin
               mismatched++;
               $display("FAIL R9 no-MMU root access: rd=%h ill=%0b fl=%0b expected rd=0 ill=0 fl=0",
                        n_rd, n_ill, n_fl);
            end
         end
      end else if (rst_n && !finished && (ill || fl || hl)) begin
         compared++; mismatched++;
         $display("FAIL R10 pulse in idle cycle: ill=%0b fl=%0b hl=%0b expected 000", ill, fl, hl);
      end
   end

   initial begin : watchdog
      #(20 * 20000);
      if (!finished) begin
         compared++; mismatched++;
         $display("FAIL watchdog expired: queue=%0d expected 0", q.size());
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   localparam logic [XLEN-1:0] ROOT_A = 64'h8000_5000_0000_1234;
   localparam logic [XLEN-1:0] ROOT_B = 64'h9000_7000_0000_00AB;
   localparam logic [XLEN-1:0] ROOT_C = 64'h8000_9000_0000_0777;
   localparam logic [XLEN-1:0] ROOT_BAD = 64'h5000_0000_0000_0001;

   initial begin : drive
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compared++;
      if (ill !== 0 || fl !== 0 || hl !== 0 || rd !== '0) begin
         mismatched++;
         $display("FAIL R1 reset state: ill=%0b fl=%0b hl=%0b rd=%h expected all zero", ill, fl, hl, rd);
      end
      issue(3'd3, 2'b11, 1, '0, "R1 root reads zero after reset");
      issue(3'd0, 2'b11, 1, '0, "R3 return with trap bit clear");
      issue(3'd5, 2'b11, 1, 64'hFFFF_FFFF_FF8F_FFFF & ~(64'h7 << 20) | (64'h1 << 22), "R2 status write sets return trap");
      issue(3'd0, 2'b00, 1, '0, "R3 return from user traps");
      issue(3'd0, 2'b11, 1, '0, "R3 return from machine traps");
      issue(3'd0, 2'b01, 0, '0, "R3 return older spec allowed");
      issue(3'd1, 2'b01, 1, '0, "R4 wait without wait trap halts");
      issue(3'd5, 2'b11, 1, 64'h1 << 21, "R2 status write sets wait trap");
      issue(3'd0, 2'b00, 1, '0, "R2 return trap now cleared");
      issue(3'd1, 2'b01, 1, '0, "R4 wait in supervisor traps");
      issue(3'd1, 2'b11, 1, '0, "R11 wait in machine halts");
      issue(3'd1, 2'b00, 1, '0, "R11 wait in user halts");
      issue(3'd1, 2'b01, 0, '0, "R4 wait older spec halts");
      issue(3'd4, 2'b11, 1, ROOT_A, "R7 machine root write accepted");
      issue(3'd3, 2'b01, 1, '0, "R6 supervisor read without VM trap");
      issue(3'd5, 2'b11, 1, 64'h1 << 20, "R2 status write sets VM trap");
      issue(3'd2, 2'b01, 1, '0, "R5 fence in supervisor traps");
      issue(3'd2, 2'b11, 1, '0, "R5 fence in machine flushes");
      issue(3'd2, 2'b00, 1, '0, "R11 fence in user flushes");
      issue(3'd3, 2'b01, 1, '0, "R6 supervisor read traps with zero data");
      issue(3'd3, 2'b11, 1, '0, "R6 machine read returns root");
      issue(3'd4, 2'b01, 1, ROOT_B, "R8 supervisor write traps");
      issue(3'd3, 2'b11, 1, '0, "R8 root unchanged after trapped write");
      issue(3'd4, 2'b01, 1, ROOT_A, "R8 unchanged value does not trap");
      issue(3'd4, 2'b11, 1, ROOT_BAD, "R7 unsupported mode ignored");
      issue(3'd3, 2'b11, 1, '0, "R7 root unchanged after bad mode");
      issue(3'd4, 2'b11, 1, ROOT_A, "R7 same value ignored");
      issue(3'd4, 2'b11, 1, ROOT_B, "R7 second mode accepted");
      issue(3'd3, 2'b01, 0, '0, "R6 older spec supervisor read allowed");
      issue(3'd2, 2'b01, 0, '0, "R5 older spec fence flushes");
      issue(3'd4, 2'b01, 0, ROOT_C, "R8 older spec supervisor write accepted");
      issue(3'd3, 2'b11, 1, '0, "R7 root holds older spec write");
      issue(3'd6, 2'b01, 1, '0, "R10 op code 6 ignored");
      issue(3'd7, 2'b01, 1, '0, "R10 op code 7 ignored");
      issue(3'd4, 2'b11, 1, '0, "R7 bare mode write accepted");
      issue(3'd5, 2'b11, 1, '0, "R2 status write clears bits");
      issue(3'd2, 2'b01, 1, '0, "R5 fence after clear flushes");
      issue(3'd3, 2'b01, 1, '0, "R6 read after clear returns zero root");
      repeat (4) @(negedge clk);
      compared++;
      if (q.size() != 0) begin
         mismatched++;
         $display("FAIL R10 results missing: queue=%0d expected 0", q.size());
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule